// File: doc/BRIEF.md
# Dual-Channel PS/2 Host Register Front End

This block puts two PS/2 channels, one for a keyboard and one for a mouse, behind a small byte-wide register bus. Each channel owns a 256-byte window: the keyboard window starts at offset 0x000 and the mouse window at offset 0x100. Inside a window only address bits [3:2] pick one of four word-spaced registers, so the four registers repeat all through the window. The line-level serialiser and the attached devices are not part of the block. Each channel instead meets a byte handshake: a one-cycle transmit strobe with its byte, and a show-ahead receive queue that the block pops.

Each channel has a control byte that software can write and read back. It has a loopback mode, in which a transmitted byte is kept locally and comes back as received data instead of going to the device. It also has a diagnostic mode, in which the two line-shadow status bits follow the forced line directions held in control. A channel raises its interrupt level whenever it holds receive data. The two levels are ORed into one interrupt output, and either channel's status register shows that combined level.

Top module: `ps2_dual_regif`

## Requirements
- R1: Address bit 8 selects the channel (0 keyboard, 1 mouse). Address bits [3:2] select the register: 0 identity/window reset, 1 receive data on read and transmit data on write, 2 control, 3 status. All other low address bits are ignored, so the registers mirror through each window, and an access never touches the other channel.
- R2: A read loads `bus_rdata` on the clock edge where `bus_rd` is sampled high, and `bus_rdata` holds that value until the next read. The identity register reads 0x00 on the keyboard channel and 0x01 on the mouse channel.
- R3: A write to control stores all 8 bits, and a read of control returns the stored byte. Bit 1 is loopback, bit 5 is diagnostic, bit 6 is data-line direction and bit 7 is clock-line direction.
- R4: With loopback (control bit 1) clear, a write to the data register makes that channel's `*_tx_valid` high for exactly the next cycle, with the byte on `*_tx_data`. The other channel's strobe stays low.
- R5: With loopback set, a write to the data register raises no transmit strobe. It stores the byte and sets the channel's loopback-pending flag.
- R6: With loopback set, a read of the data register returns the stored byte and clears the loopback-pending flag.
- R7: With loopback clear, a read of the data register returns `*_rx_data` and drives `*_rx_pop` high in that same cycle when `*_rx_nonempty` is high. When the queue is empty it returns 0x00 and does not pop.
- R8: Status bit 0 is the loopback-pending flag when loopback is set, and `*_rx_nonempty` otherwise. Status bits 1, 2, 3 and 5 read 0.
- R9: Status bits 6 (data shadow) and 7 (clock shadow) read 1. When diagnostic mode (control bit 5) is set, each of them reads 0 while its direction bit (control bit 6 or bit 7) is 0.
- R10: A channel's interrupt level is status bit 0's condition. Status bit 4 on either channel is the OR of both levels in the current cycle, and `irq` carries that OR one clock later.
- R11: Synchronous `rst` clears both control bytes, both pending flags, both stored bytes, `bus_rdata`, `irq` and the strobes. A write to a channel's identity register clears only that channel's control byte, pending flag and stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 9 | Byte address across both windows |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Combined interrupt, registered |
| kbd_tx_valid | output | 1 | Keyboard transmit byte strobe |
| kbd_tx_data | output | 8 | Keyboard transmit byte |
| kbd_rx_nonempty | input | 1 | Keyboard receive queue holds a byte |
| kbd_rx_data | input | 8 | Keyboard receive queue head |
| kbd_rx_pop | output | 1 | Keyboard receive queue pop |
| mse_tx_valid | output | 1 | Mouse transmit byte strobe |
| mse_tx_data | output | 8 | Mouse transmit byte |
| mse_rx_nonempty | input | 1 | Mouse receive queue holds a byte |
| mse_rx_data | input | 8 | Mouse receive queue head |
| mse_rx_pop | output | 1 | Mouse receive queue pop |

## Verification
The assertions watch on every cycle that each transmit strobe follows a non-loopback data write to its own window, and that a loopback write raises no strobe but sets the pending flag. They also check that a loopback read clears that flag, that a pop happens only on a read of a non-empty queue, that the interrupt rises only when some receive source is present, and that read data moves only after a read. The bench scenarios cover the things that only a sequence of accesses shows: the byte values that come back from each register, address mirroring, the exact status encodings under the diagnostic settings, the shared interrupt bit as seen from the idle channel, and the difference between a window reset and a full reset.

// File: rtl/ps2rif_pkg.sv
package ps2rif_pkg;
  // register index taken from address bits [3:2]
  localparam int unsigned REG_IDENT = 0;
  localparam int unsigned REG_DATA  = 1;
  localparam int unsigned REG_CTL   = 2;
  localparam int unsigned REG_STAT  = 3;

  // control bit positions
  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_LOOP = 1;
  localparam int unsigned CB_DIAG = 5;
  localparam int unsigned CB_DDIR = 6;
  localparam int unsigned CB_CDIR = 7;

  // status bit positions
  localparam int unsigned SB_RXNE = 0;
  localparam int unsigned SB_TXNE = 1;
  localparam int unsigned SB_TOUT = 2;
  localparam int unsigned SB_PAR  = 3;
  localparam int unsigned SB_IRQ  = 4;
  localparam int unsigned SB_DSHD = 6;
  localparam int unsigned SB_CSHD = 7;

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [1:0] idx;
  } acc_t;
endpackage

// File: rtl/ps2rif_decode.sv
module ps2rif_decode
  import ps2rif_pkg::*;
#(
  parameter int unsigned ADDR_W  = 9,
  parameter int unsigned WIN_LSB = 8,
  parameter int unsigned NPORT   = 2,
  localparam int unsigned PSEL_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  input  logic               rd,
  output logic [PSEL_W-1:0]  psel,
  output acc_t [NPORT-1:0]   acc
);
  assign psel = addr[WIN_LSB +: PSEL_W];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic hit;
    assign hit        = (psel == PSEL_W'(p));
    assign acc[p].wr  = wr & hit;
    assign acc[p].rd  = rd & hit;
    assign acc[p].idx = addr[3:2];
  end
endmodule

// File: rtl/ps2rif_channel.sv
module ps2rif_channel
  import ps2rif_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PORT_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_t              acc,
  input  logic [DATA_W-1:0] wdata,
  input  logic              irq_any,
  input  logic              rx_nonempty,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_pop,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] rd_val,
  output logic              level,
  output logic              loop_on,
  output logic              pend
);
  logic [DATA_W-1:0] ctl_q;
  logic [DATA_W-1:0] lbyte_q;
  logic              pend_q;
  logic [DATA_W-1:0] stat;
  logic              data_rd;

  assign loop_on = ctl_q[CB_LOOP];
  assign pend    = pend_q;
  assign data_rd = acc.rd && (acc.idx == 2'(REG_DATA));
  assign rx_pop  = data_rd && !loop_on && rx_nonempty;
  assign level   = loop_on ? pend_q : rx_nonempty;

  always_comb begin
    stat          = '0;
    stat[SB_RXNE] = level;
    stat[SB_IRQ]  = irq_any;
    stat[SB_DSHD] = !(ctl_q[CB_DIAG] && !ctl_q[CB_DDIR]);
    stat[SB_CSHD] = !(ctl_q[CB_DIAG] && !ctl_q[CB_CDIR]);
  end

  always_comb begin
    case (acc.idx)
      2'(REG_IDENT): rd_val = DATA_W'(PORT_ID);
      2'(REG_DATA):  rd_val = loop_on ? lbyte_q : (rx_nonempty ? rx_data : '0);
      2'(REG_CTL):   rd_val = ctl_q;
      default:       rd_val = stat;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      lbyte_q  <= '0;
      pend_q   <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= 1'b0;
      if (data_rd && loop_on) pend_q <= 1'b0;
      if (acc.wr) begin
        case (acc.idx)
          2'(REG_IDENT): begin
            ctl_q   <= '0;
            lbyte_q <= '0;
            pend_q  <= 1'b0;
          end
          2'(REG_DATA): begin
            if (loop_on) begin
              lbyte_q <= wdata;
              pend_q  <= 1'b1;
            end else begin
              tx_valid <= 1'b1;
              tx_data  <= wdata;
            end
          end
          2'(REG_CTL): ctl_q <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ps2_dual_regif.sv
module ps2_dual_regif
  import ps2rif_pkg::*;
#(
  parameter int unsigned ADDR_W  = 9,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned WIN_LSB = 8,
  localparam int unsigned NPORT  = 2,
  localparam int unsigned PSEL_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              kbd_tx_valid,
  output logic [DATA_W-1:0] kbd_tx_data,
  input  logic              kbd_rx_nonempty,
  input  logic [DATA_W-1:0] kbd_rx_data,
  output logic              kbd_rx_pop,
  output logic              mse_tx_valid,
  output logic [DATA_W-1:0] mse_tx_data,
  input  logic              mse_rx_nonempty,
  input  logic [DATA_W-1:0] mse_rx_data,
  output logic              mse_rx_pop
);
  logic [PSEL_W-1:0]             psel;
  acc_t [NPORT-1:0]              acc;
  logic [NPORT-1:0]              nonempty_v, pop_v, txv_v, level_v, loop_v, pend_v;
  logic [NPORT-1:0][DATA_W-1:0]  rxd_v, txd_v, rdv_v;
  logic                          irq_any;

  assign nonempty_v = {mse_rx_nonempty, kbd_rx_nonempty};
  assign rxd_v      = {mse_rx_data, kbd_rx_data};
  assign kbd_rx_pop   = pop_v[0];
  assign mse_rx_pop   = pop_v[1];
  assign kbd_tx_valid = txv_v[0];
  assign mse_tx_valid = txv_v[1];
  assign kbd_tx_data  = txd_v[0];
  assign mse_tx_data  = txd_v[1];
  assign irq_any      = |level_v;

  ps2rif_decode #(
    .ADDR_W (ADDR_W),
    .WIN_LSB(WIN_LSB),
    .NPORT  (NPORT)
  ) u_dec (
    .addr(bus_addr),
    .wr  (bus_wr),
    .rd  (bus_rd),
    .psel(psel),
    .acc (acc)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_ch
    ps2rif_channel #(
      .DATA_W (DATA_W),
      .PORT_ID(p)
    ) u_ch (
      .clk        (clk),
      .rst        (rst),
      .acc        (acc[p]),
      .wdata      (bus_wdata),
      .irq_any    (irq_any),
      .rx_nonempty(nonempty_v[p]),
      .rx_data    (rxd_v[p]),
      .rx_pop     (pop_v[p]),
      .tx_valid   (txv_v[p]),
      .tx_data    (txd_v[p]),
      .rd_val     (rdv_v[p]),
      .level      (level_v[p]),
      .loop_on    (loop_v[p]),
      .pend       (pend_v[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= irq_any;
      if (bus_rd) bus_rdata <= rdv_v[psel];
    end
  end
endmodule

// File: rtl/ps2rif_chk.sv
module ps2rif_chk #(
  parameter int unsigned ADDR_W  = 9,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned WIN_LSB = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              kbd_tx_valid,
  input logic              mse_tx_valid,
  input logic              kbd_rx_pop,
  input logic              kbd_rx_nonempty,
  input logic              mse_rx_pop,
  input logic              mse_rx_nonempty,
  input logic [1:0]        loop_v,
  input logic [1:0]        pend_v
);
  logic kdat, mdat;
  assign kdat = !bus_addr[WIN_LSB] && (bus_addr[3:2] == 2'd1);
  assign mdat =  bus_addr[WIN_LSB] && (bus_addr[3:2] == 2'd1);

  p_kbd_tx_src_r4: assert property (@(posedge clk) disable iff (rst)
    kbd_tx_valid |-> $past(bus_wr && kdat && !loop_v[0]));
  p_mse_tx_src_r4: assert property (@(posedge clk) disable iff (rst)
    mse_tx_valid |-> $past(bus_wr && mdat && !loop_v[1]));
  p_loop_no_tx_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && kdat && loop_v[0]) |=> (!kbd_tx_valid && pend_v[0]));
  p_loop_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && kdat && loop_v[0]) |=> !pend_v[0]);
  p_kbd_pop_gate_r7: assert property (@(posedge clk) disable iff (rst)
    kbd_rx_pop |-> (kbd_rx_nonempty && bus_rd));
  p_mse_pop_gate_r7: assert property (@(posedge clk) disable iff (rst)
    mse_rx_pop |-> (mse_rx_nonempty && bus_rd));
  p_irq_source_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(kbd_rx_nonempty || mse_rx_nonempty || (|pend_v)));
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

bind ps2_dual_regif ps2rif_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WIN_LSB(WIN_LSB)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .bus_addr       (bus_addr),
  .bus_wr         (bus_wr),
  .bus_rd         (bus_rd),
  .bus_rdata      (bus_rdata),
  .irq            (irq),
  .kbd_tx_valid   (kbd_tx_valid),
  .mse_tx_valid   (mse_tx_valid),
  .kbd_rx_pop     (kbd_rx_pop),
  .kbd_rx_nonempty(kbd_rx_nonempty),
  .mse_rx_pop     (mse_rx_pop),
  .mse_rx_nonempty(mse_rx_nonempty),
  .loop_v         (loop_v),
  .pend_v         (pend_v)
);

// File: tb/sim_ps2_dual_regif.sv
module sim_ps2_dual_regif;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       is_rd;
    logic [8:0] addr;
    logic [7:0] data;
    logic [7:0] req;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VT [NVEC] = '{
    '{1'b1, 9'h000, 8'h00, 8'd2},   // R2 keyboard identity
    '{1'b1, 9'h100, 8'h01, 8'd2},   // R2 mouse identity
    '{1'b0, 9'h008, 8'hA5, 8'd3},   // R3 write keyboard control
    '{1'b1, 9'h008, 8'hA5, 8'd3},
    '{1'b1, 9'h0F8, 8'hA5, 8'd1},   // R1 mirrored control
    '{1'b1, 9'h108, 8'h00, 8'd1},   // R1 mouse untouched
    '{1'b1, 9'h00C, 8'h80, 8'd9},   // R9 diag, data dir 0
    '{1'b1, 9'h10C, 8'hC0, 8'd9},   // R9 no diag
    '{1'b0, 9'h108, 8'h60, 8'd9},
    '{1'b1, 9'h10C, 8'h40, 8'd9},   // R9 diag, clock dir 0
    '{1'b0, 9'h008, 8'h03, 8'd5},
    '{1'b0, 9'h004, 8'h5A, 8'd5},   // R5 loopback write
    '{1'b1, 9'h00C, 8'hD1, 8'd8},   // R8 pending + R10 bit 4
    '{1'b1, 9'h10C, 8'h50, 8'd10},  // R10 shared bit on mouse
    '{1'b1, 9'h004, 8'h5A, 8'd6},   // R6 loopback read
    '{1'b1, 9'h00C, 8'hC0, 8'd6},   // R6 flag cleared
    '{1'b0, 9'h000, 8'hFF, 8'd11},  // R11 window reset
    '{1'b1, 9'h008, 8'h00, 8'd11},
    '{1'b1, 9'h1F0, 8'h01, 8'd1}    // R1 mirrored identity
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;
  logic       kbd_tx_valid, mse_tx_valid, kbd_rx_pop, mse_rx_pop;
  logic [7:0] kbd_tx_data, mse_tx_data;
  logic       kbd_rx_nonempty = 1'b0, mse_rx_nonempty = 1'b0;
  logic [7:0] kbd_rx_data = '0, mse_rx_data = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_dual_regif u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .kbd_tx_valid(kbd_tx_valid), .kbd_tx_data(kbd_tx_data),
    .kbd_rx_nonempty(kbd_rx_nonempty), .kbd_rx_data(kbd_rx_data), .kbd_rx_pop(kbd_rx_pop),
    .mse_tx_valid(mse_tx_valid), .mse_tx_data(mse_tx_data),
    .mse_rx_nonempty(mse_rx_nonempty), .mse_rx_data(mse_rx_data), .mse_rx_pop(mse_rx_pop)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [7:0] d, output logic popk, output logic popm);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    popk = kbd_rx_pop; popm = mse_rx_pop;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic pk, pm;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 rdata", bus_rdata, 8'h00);
    chk("R11 irq", {7'b0, irq}, 8'h00);
    chk("R11 strobes", {6'b0, mse_tx_valid, kbd_tx_valid}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      if (VT[i].is_rd) begin
        rd(VT[i].addr, d, pk, pm);
        chk($sformatf("R%0d vec%0d", VT[i].req, i), d, VT[i].data);
      end else begin
        wr(VT[i].addr, VT[i].data);
      end
    end

    // R4 forward to keyboard only
    wr(9'h004, 8'h3C);
    chk("R4 kbd strobe", {kbd_tx_valid, mse_tx_valid, 6'b0}, 8'h80);
    chk("R4 kbd byte", kbd_tx_data, 8'h3C);
    @(negedge clk);
    chk("R4 one cycle", {7'b0, kbd_tx_valid}, 8'h00);
    wr(9'h104, 8'hC3);
    chk("R4 mse strobe", {kbd_tx_valid, mse_tx_valid, 6'b0}, 8'h40);
    chk("R4 mse byte", mse_tx_data, 8'hC3);

    // R5 loopback write sends nothing; R10 irq follows a cycle later
    wr(9'h008, 8'h02);
    wr(9'h004, 8'h77);
    chk("R5 no strobe", {7'b0, kbd_tx_valid}, 8'h00);
    chk("R10 irq lag", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R10 irq set", {7'b0, irq}, 8'h01);
    rd(9'h004, d, pk, pm);
    chk("R6 loop byte", d, 8'h77);
    chk("R6 no pop", {7'b0, pk}, 8'h00);
    @(negedge clk);
    chk("R10 irq clear", {7'b0, irq}, 8'h00);

    // R7 device queue path
    wr(9'h008, 8'h00);
    kbd_rx_nonempty = 1'b1; kbd_rx_data = 8'h99;
    rd(9'h00C, d, pk, pm);
    chk("R8 kbd status", d, 8'hD1);
    rd(9'h10C, d, pk, pm);
    chk("R10 mse status", d, 8'h50);
    chk("R10 irq dev", {7'b0, irq}, 8'h01);
    rd(9'h004, d, pk, pm);
    chk("R7 pop", {6'b0, pm, pk}, 8'h01);
    chk("R7 data", d, 8'h99);
    kbd_rx_nonempty = 1'b0;
    rd(9'h004, d, pk, pm);
    chk("R7 empty pop", {6'b0, pm, pk}, 8'h00);
    chk("R7 empty data", d, 8'h00);
    mse_rx_nonempty = 1'b1; mse_rx_data = 8'h42;
    rd(9'h104, d, pk, pm);
    chk("R7 mse pop", {6'b0, pm, pk}, 8'h02);
    chk("R7 mse data", d, 8'h42);
    mse_rx_nonempty = 1'b0;

    // R11 window reset is per channel
    wr(9'h008, 8'h81);
    wr(9'h108, 8'h42);
    wr(9'h100, 8'h00);
    rd(9'h008, d, pk, pm);
    chk("R11 kbd kept", d, 8'h81);
    rd(9'h108, d, pk, pm);
    chk("R11 mse cleared", d, 8'h00);

    // R11 full reset clears loopback state
    wr(9'h008, 8'h02);
    wr(9'h004, 8'hEE);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(9'h008, d, pk, pm);
    chk("R11 ctl reset", d, 8'h00);
    rd(9'h00C, d, pk, pm);
    chk("R11 pend reset", d, 8'hC0);
    chk("R11 irq reset", {7'b0, irq}, 8'h00);

    finish_run();
  end
endmodule